// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides which power mode a small processor core is in. It covers nine modes: reset, two active modes on the main clock (full speed and divided speed), a mode on the slow subclock (sub-active), four halted low-power modes (sleep, software standby, watch, sub-sleep) and hardware standby. Each cycle it looks at two external pins (a standby pin and a reset pin) and at a sleep-instruction strobe. The strobe comes with four mode-control bits. The block also watches a set of wake request lines and an interrupt-accept handshake.

From these inputs it drives the current mode code and the enables for the main oscillator and the subclock. It also drives a CPU-halt flag and a one-cycle clock-switch pulse. A return from the subclock to the main clock waits for the main oscillator to settle. That wait is counted in subclock ticks, and its length is set by a 3-bit select. A sleep strobe whose control bits form no legal move from the current mode leaves the mode as it is and sets a sticky error flag.

Top module: `pwr_mode_seq`

## Requirements
- R1: The standby pin (`stby_n_i`) low moves the mode to hardware standby (code 8) at the next clock edge. This happens from any mode and wins over the reset pin. The cycle after the standby pin is seen high again, hardware standby moves to reset (code 0), even if the reset pin is still low.
- R2: The reset pin (`res_n_i`) low moves every mode except hardware standby to reset at the next edge. Reset with the reset pin high moves to high-speed (code 1) at the next edge.
- R3: In the two main-clock active modes, the mode follows the divider select each cycle: 0 gives high-speed (code 1) and any other value gives medium-speed (code 2).
- R4: A sleep strobe in high-speed or medium-speed decodes the control bits. SSBY=0 with LSON=0 gives sleep (code 3). SSBY=1, PSS=0, LSON=0 gives software standby (code 4). SSBY=1, PSS=1, DTON=0 gives watch (code 5).
- R5: A watch or sub-active request (SSBY=1, PSS=1 with DTON=0, or SSBY=PSS=DTON=LSON=1) made in medium-speed leaves the mode unchanged.
- R6: In high-speed, a strobe with SSBY=PSS=DTON=LSON=1 keeps the mode at high-speed for one cycle. During that cycle `clk_sw_o` is 1. The mode then becomes sub-active (code 6).
- R7: Sleep wakes on NMI, any IRQ line or either watchdog. Software standby wakes only on NMI or an IRQ line. Both return to the active mode that the divider select picks.
- R8: Watch wakes on NMI, an IRQ line or watchdog-1, and ignores watchdog-0. It moves to sub-active when LSON=1 and to high-speed when LSON=0.
- R9: A sub-active strobe with SSBY=0, PSS=1, LSON=1 gives sub-sleep (code 7). Sub-sleep returns to sub-active on NMI, an IRQ line or either watchdog.
- R10: A sub-active strobe with SSBY=1, PSS=1, DTON=1, LSON=0 keeps sub-active with the main oscillator enabled for 2^(8+STS) subclock ticks. It then raises `clk_sw_o` for exactly one cycle and then enters high-speed.
- R11: A low-power mode changes only in a cycle where `irq_ack_i` is 1. At that point an accepted wake source must be active or must have been seen since entry. An accept with no accepted source, or a source with no accept, leaves the mode unchanged.
- R12: A sleep strobe that matches no legal move leaves the mode unchanged and sets `sleep_err_o`. The flag stays set until the mode enters reset or hardware standby.
- R13: Outputs per mode, outside the R6 and R10 steps. `main_osc_en_o` is 1 only in reset, high-speed, medium-speed and sleep. `sub_en_o` is 1 only in watch, sub-active and sub-sleep. `cpu_halt_o` is 1 in reset, sleep, software standby, watch, sub-sleep and hardware standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset; gives reset mode, error cleared |
| stby_n_i | input | 1 | Standby pin, active low |
| res_n_i | input | 1 | Reset pin, active low |
| sleep_i | input | 1 | One-cycle sleep-instruction strobe |
| ssby_i | input | 1 | Standby select control bit |
| pss_i | input | 1 | Subclock-path select control bit |
| dton_i | input | 1 | Direct-transfer control bit |
| lson_i | input | 1 | Low-speed-on control bit |
| ckdiv_i | input | DIV_W | Main clock divider select |
| sts_i | input | STS_W | Oscillator settling-time select |
| subclk_tick_i | input | 1 | One pulse per subclock period |
| nmi_i | input | 1 | Non-maskable wake request |
| irq_i | input | NIRQ | External IRQ wake requests |
| wdt0_i | input | 1 | Watchdog-0 wake request |
| wdt1_i | input | 1 | Watchdog-1 wake request |
| irq_ack_i | input | 1 | Interrupt-accept handshake |
| mode_o | output | 4 | Current mode code (0..8 as in R1 to R9) |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_en_o | output | 1 | Subclock enable |
| cpu_halt_o | output | 1 | CPU halted |
| clk_sw_o | output | 1 | One-cycle clock-switch pulse |
| sleep_err_o | output | 1 | Sticky illegal-sleep flag |

## Verification
The properties assume that the pins, the strobe and the wake lines are synchronous to `clk`. They also assume that `rst` is held high for at least one edge before any check runs, so every `$past` value comes from a defined cycle. The sleep strobe is treated as a pulse, one per instruction. The stimulus follows these rules by changing every input on the falling clock edge and raising `sleep_i` for one cycle at a time. It leaves `rst` low once the sequence starts, and it keeps `subclk_tick_i` high so that the wait lengths can be counted exactly.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int DEF_DIV_W    = 3;
    localparam int DEF_STS_W    = 3;
    localparam int DEF_STS_BASE = 8;
    localparam int DEF_NIRQ     = 6;

    typedef enum logic [3:0] {
        MD_RESET  = 4'd0,
        MD_HIGH   = 4'd1,
        MD_MED    = 4'd2,
        MD_SLEEP  = 4'd3,
        MD_SSTBY  = 4'd4,
        MD_WATCH  = 4'd5,
        MD_SUBACT = 4'd6,
        MD_SUBSLP = 4'd7,
        MD_HWSTBY = 4'd8
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_SWITCH
    } phase_e;

    typedef struct packed {
        logic ssby;
        logic pss;
        logic dton;
        logic lson;
    } ctl_t;

    typedef enum logic [2:0] {
        DC_NONE,
        DC_ILLEGAL,
        DC_SLEEP,
        DC_SSTBY,
        DC_WATCH,
        DC_TOSUB,
        DC_SUBSLP,
        DC_TOMAIN
    } dec_e;

    function automatic logic is_low_power(mode_e m);
        return (m == MD_SLEEP) || (m == MD_SSTBY) || (m == MD_WATCH) || (m == MD_SUBSLP);
    endfunction

    function automatic logic osc_on(mode_e m);
        return (m == MD_RESET) || (m == MD_HIGH) || (m == MD_MED) || (m == MD_SLEEP);
    endfunction

    function automatic logic sub_on(mode_e m);
        return (m == MD_WATCH) || (m == MD_SUBACT) || (m == MD_SUBSLP);
    endfunction

    function automatic logic halted(mode_e m);
        return (m != MD_HIGH) && (m != MD_MED) && (m != MD_SUBACT);
    endfunction

endpackage

// File: rtl/pwr_sleep_decode.sv
module pwr_sleep_decode
    import pwr_mode_pkg::*;
(
    input  mode_e mode,
    input  ctl_t  ctl,
    output dec_e  dec
);
    logic from_high;
    assign from_high = (mode == MD_HIGH);

    always_comb begin
        dec = DC_NONE;
        unique case (mode)
            MD_HIGH, MD_MED: begin
                if (!ctl.ssby && !ctl.lson)
                    dec = DC_SLEEP;
                else if (ctl.ssby && !ctl.pss && !ctl.lson)
                    dec = DC_SSTBY;
                else if (ctl.ssby && ctl.pss && !ctl.dton)
                    dec = from_high ? DC_WATCH : DC_ILLEGAL;
                else if (ctl.ssby && ctl.pss && ctl.dton && ctl.lson)
                    dec = from_high ? DC_TOSUB : DC_ILLEGAL;
                else
                    dec = DC_ILLEGAL;
            end
            MD_SUBACT: begin
                if (!ctl.ssby && ctl.pss && ctl.lson)
                    dec = DC_SUBSLP;
                else if (ctl.ssby && ctl.pss && ctl.dton && !ctl.lson)
                    dec = DC_TOMAIN;
                else
                    dec = DC_ILLEGAL;
            end
            default: dec = DC_NONE;
        endcase
    end
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
    import pwr_mode_pkg::*;
#(
    parameter int NIRQ = DEF_NIRQ
) (
    input  logic            clk,
    input  logic            rst,
    input  mode_e           mode,
    input  logic            nmi,
    input  logic [NIRQ-1:0] irq,
    input  logic            wdt0,
    input  logic            wdt1,
    input  logic            clear,
    output logic            wake_ok
);
    logic ext_any;
    logic qual;
    logic pend_q;

    assign ext_any = nmi | (|irq);

    always_comb begin
        unique case (mode)
            MD_SLEEP, MD_SUBSLP: qual = ext_any | wdt0 | wdt1;
            MD_SSTBY:            qual = ext_any;
            MD_WATCH:            qual = ext_any | wdt1;
            default:             qual = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) pend_q <= 1'b0;
        else              pend_q <= pend_q | qual;
    end

    assign wake_ok = qual | pend_q;
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
    parameter int STS_W    = 3,
    parameter int STS_BASE = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic [STS_W-1:0] sts,
    output logic             done
);
    localparam int MAX_EXP = STS_BASE + (1 << STS_W) - 1;
    localparam int CNT_W   = MAX_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [STS_W-1:0] sts_q;
    logic [CNT_W-1:0] last;

    assign last = {CNT_W{1'b1}} >> (MAX_EXP - (STS_BASE + int'(sts_q)));
    assign done = tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sts_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            sts_q <= sts;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int NIRQ     = DEF_NIRQ,
    parameter int DIV_W    = DEF_DIV_W,
    parameter int STS_W    = DEF_STS_W,
    parameter int STS_BASE = DEF_STS_BASE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stby_n_i,
    input  logic             res_n_i,
    input  logic             sleep_i,
    input  logic             ssby_i,
    input  logic             pss_i,
    input  logic             dton_i,
    input  logic             lson_i,
    input  logic [DIV_W-1:0] ckdiv_i,
    input  logic [STS_W-1:0] sts_i,
    input  logic             subclk_tick_i,
    input  logic             nmi_i,
    input  logic [NIRQ-1:0]  irq_i,
    input  logic             wdt0_i,
    input  logic             wdt1_i,
    input  logic             irq_ack_i,
    output logic [3:0]       mode_o,
    output logic             main_osc_en_o,
    output logic             sub_en_o,
    output logic             cpu_halt_o,
    output logic             clk_sw_o,
    output logic             sleep_err_o
);
    mode_e  mode_q, mode_d;
    phase_e phase_q, phase_d;
    logic   err_q, err_d;
    logic   tmr_start, tmr_done;
    logic   wake_ok, wake_go;
    ctl_t   ctl;
    dec_e   dec;
    mode_e  active_mode;

    assign ctl         = '{ssby: ssby_i, pss: pss_i, dton: dton_i, lson: lson_i};
    assign active_mode = (ckdiv_i == '0) ? MD_HIGH : MD_MED;
    assign wake_go     = irq_ack_i && wake_ok;

    pwr_sleep_decode u_dec (
        .mode (mode_q),
        .ctl  (ctl),
        .dec  (dec)
    );

    pwr_wake_qual #(.NIRQ(NIRQ)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .nmi     (nmi_i),
        .irq     (irq_i),
        .wdt0    (wdt0_i),
        .wdt1    (wdt1_i),
        .clear   (mode_d != mode_q),
        .wake_ok (wake_ok)
    );

    pwr_osc_timer #(.STS_W(STS_W), .STS_BASE(STS_BASE)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .tick  (subclk_tick_i),
        .sts   (sts_i),
        .done  (tmr_done)
    );

    always_comb begin
        mode_d    = mode_q;
        phase_d   = phase_q;
        err_d     = err_q;
        tmr_start = 1'b0;
        if (!stby_n_i) begin
            mode_d  = MD_HWSTBY;
            phase_d = PH_IDLE;
        end else if (mode_q == MD_HWSTBY) begin
            mode_d  = MD_RESET;
        end else if (!res_n_i) begin
            mode_d  = MD_RESET;
            phase_d = PH_IDLE;
        end else if (mode_q == MD_RESET) begin
            mode_d  = MD_HIGH;
        end else begin
            unique case (phase_q)
                PH_SWITCH: begin
                    mode_d  = (mode_q == MD_HIGH) ? MD_SUBACT : MD_HIGH;
                    phase_d = PH_IDLE;
                end
                PH_WAIT: begin
                    if (tmr_done) phase_d = PH_SWITCH;
                end
                default: begin
                    unique case (mode_q)
                        MD_HIGH, MD_MED: begin
                            if (sleep_i) begin
                                unique case (dec)
                                    DC_SLEEP: mode_d  = MD_SLEEP;
                                    DC_SSTBY: mode_d  = MD_SSTBY;
                                    DC_WATCH: mode_d  = MD_WATCH;
                                    DC_TOSUB: phase_d = PH_SWITCH;
                                    default:  err_d   = 1'b1;
                                endcase
                            end else begin
                                mode_d = active_mode;
                            end
                        end
                        MD_SUBACT: begin
                            if (sleep_i) begin
                                unique case (dec)
                                    DC_SUBSLP: mode_d = MD_SUBSLP;
                                    DC_TOMAIN: begin
                                        phase_d   = PH_WAIT;
                                        tmr_start = 1'b1;
                                    end
                                    default:   err_d  = 1'b1;
                                endcase
                            end
                        end
                        MD_SLEEP, MD_SSTBY: if (wake_go) mode_d = active_mode;
                        MD_WATCH:  if (wake_go) mode_d = lson_i ? MD_SUBACT : MD_HIGH;
                        MD_SUBSLP: if (wake_go) mode_d = MD_SUBACT;
                        default: ;
                    endcase
                end
            endcase
        end
        if (mode_d == MD_RESET || mode_d == MD_HWSTBY) err_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MD_RESET;
            phase_q <= PH_IDLE;
            err_q   <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            phase_q <= phase_d;
            err_q   <= err_d;
        end
    end

    assign mode_o        = mode_q;
    assign main_osc_en_o = osc_on(mode_q) || (phase_q != PH_IDLE);
    assign sub_en_o      = sub_on(mode_q);
    assign cpu_halt_o    = halted(mode_q);
    assign clk_sw_o      = (phase_q == PH_SWITCH);
    assign sleep_err_o   = err_q;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
    import pwr_mode_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stby_n_i,
    input logic       res_n_i,
    input logic       irq_ack_i,
    input logic [3:0] mode_o,
    input logic       main_osc_en_o,
    input logic       clk_sw_o,
    input logic       sleep_err_o
);
    mode_e md;
    assign md = mode_e'(mode_o);

    p_stby_wins_r1: assert property (@(posedge clk) disable iff (rst)
        !stby_n_i |=> md == MD_HWSTBY);

    p_reset_pin_r2: assert property (@(posedge clk) disable iff (rst)
        (stby_n_i && !res_n_i && md != MD_HWSTBY) |=> md == MD_RESET);

    p_watch_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (md == MD_WATCH && $past(md) != MD_WATCH) |-> $past(md) == MD_HIGH);

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        clk_sw_o |=> !clk_sw_o);

    p_return_via_switch_r10: assert property (@(posedge clk) disable iff (rst)
        (md == MD_HIGH && $past(md) == MD_SUBACT) |-> $past(clk_sw_o));

    p_osc_at_switch_r10: assert property (@(posedge clk) disable iff (rst)
        clk_sw_o |-> main_osc_en_o);

    p_wake_needs_ack_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(is_low_power(md)) && md != $past(md) && $past(stby_n_i) && $past(res_n_i))
        |-> $past(irq_ack_i));

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_err_o) |-> (md == MD_RESET || md == MD_HWSTBY));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .stby_n_i      (stby_n_i),
    .res_n_i       (res_n_i),
    .irq_ack_i     (irq_ack_i),
    .mode_o        (mode_o),
    .main_osc_en_o (main_osc_en_o),
    .clk_sw_o      (clk_sw_o),
    .sleep_err_o   (sleep_err_o)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
    localparam logic [3:0] M_RST = 4'd0, M_HI = 4'd1, M_MD = 4'd2, M_SL = 4'd3,
                           M_SS = 4'd4, M_WA = 4'd5, M_SA = 4'd6, M_SU = 4'd7, M_HW = 4'd8;

    typedef struct packed {
        logic       sn;
        logic       rn;
        logic       sl;
        logic [3:0] ctl;   // {SSBY, PSS, DTON, LSON}
        logic [2:0] div;
        logic [3:0] wk;    // {NMI, IRQ, WDT0, WDT1}
        logic       ack;
        logic [3:0] em;
        logic       ee;
        logic       esw;
        logic [7:0] rq;
    } vec_t;

    function automatic vec_t V(input logic sn, input logic rn, input logic sl,
                               input logic [3:0] c, input logic [2:0] d,
                               input logic [3:0] w, input logic a,
                               input logic [3:0] m, input logic e, input logic s,
                               input logic [7:0] r);
        V = '{sn: sn, rn: rn, sl: sl, ctl: c, div: d, wk: w, ack: a,
              em: m, ee: e, esw: s, rq: r};
    endfunction

    localparam int NV = 35;
    localparam vec_t TBL [NV] = '{
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd2),   // R2 reset release
        V(1,1,0,4'b0000,3'd3,4'b0000,0, M_MD,0,0, 8'd3),   // R3 divided
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd3),   // R3 back to full
        V(1,1,1,4'b0000,3'd0,4'b0000,0, M_SL,0,0, 8'd4),   // R4 sleep
        V(1,1,0,4'b0000,3'd0,4'b0010,0, M_SL,0,0, 8'd11),  // R11 source, no accept
        V(1,1,0,4'b0000,3'd0,4'b0000,1, M_HI,0,0, 8'd7),   // R7 accept of seen WDT0
        V(1,1,1,4'b1000,3'd0,4'b0000,0, M_SS,0,0, 8'd4),   // R4 sw standby
        V(1,1,0,4'b0000,3'd0,4'b0001,1, M_SS,0,0, 8'd7),   // R7 WDT1 ignored
        V(1,1,0,4'b0000,3'd0,4'b0000,1, M_SS,0,0, 8'd11),  // R11 bare accept
        V(1,1,0,4'b0000,3'd2,4'b0100,1, M_MD,0,0, 8'd7),   // R7 IRQ wake to divided
        V(1,1,1,4'b1100,3'd2,4'b0000,0, M_MD,1,0, 8'd5),   // R5 watch from medium
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,1,0, 8'd12),  // R12 sticky
        V(1,1,1,4'b1100,3'd0,4'b0000,0, M_WA,1,0, 8'd4),   // R4 watch
        V(1,1,0,4'b0000,3'd0,4'b0010,1, M_WA,1,0, 8'd8),   // R8 WDT0 ignored
        V(1,1,0,4'b0001,3'd0,4'b0001,1, M_SA,1,0, 8'd8),   // R8 LSON=1 to sub
        V(1,1,1,4'b0101,3'd0,4'b0000,0, M_SU,1,0, 8'd9),   // R9 sub-sleep
        V(1,1,0,4'b0000,3'd0,4'b0010,1, M_SA,1,0, 8'd9),   // R9 WDT0 wake
        V(1,1,1,4'b0000,3'd0,4'b0000,0, M_SA,1,0, 8'd12),  // R12 illegal in sub
        V(1,0,0,4'b0000,3'd0,4'b0000,0, M_RST,0,0, 8'd2),  // R2 pin reset
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd2),
        V(1,1,1,4'b1100,3'd0,4'b0000,0, M_WA,0,0, 8'd4),
        V(1,1,0,4'b0000,3'd0,4'b1000,1, M_HI,0,0, 8'd8),   // R8 LSON=0 to high
        V(1,1,1,4'b1111,3'd0,4'b0000,0, M_HI,0,1, 8'd6),   // R6 switch step
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_SA,0,0, 8'd6),
        V(0,0,0,4'b0000,3'd0,4'b0000,0, M_HW,0,0, 8'd1),   // R1 over reset
        V(1,0,0,4'b0000,3'd0,4'b0000,0, M_RST,0,0, 8'd1),  // R1 leave via reset
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd2),
        V(1,1,1,4'b1001,3'd0,4'b0000,0, M_HI,1,0, 8'd12),  // R12 no match
        V(0,1,0,4'b0000,3'd0,4'b0000,0, M_HW,0,0, 8'd1),   // R1 clears flag
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_RST,0,0, 8'd1),
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd2),
        V(1,1,0,4'b0000,3'd5,4'b0000,0, M_MD,0,0, 8'd3),
        V(1,1,1,4'b1111,3'd5,4'b0000,0, M_MD,1,0, 8'd5),   // R5 sub from medium
        V(1,0,0,4'b0000,3'd0,4'b0000,0, M_RST,0,0, 8'd2),
        V(1,1,0,4'b0000,3'd0,4'b0000,0, M_HI,0,0, 8'd2)
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stby_n = 1'b1, res_n = 1'b1, sleep = 1'b0;
    logic [3:0] ctl = '0;
    logic [2:0] ckdiv = '0, sts = '0;
    logic       tick = 1'b1;
    logic       nmi = 1'b0, wdt0 = 1'b0, wdt1 = 1'b0, ack = 1'b0;
    logic [5:0] irq = '0;
    logic [3:0] mode;
    logic       osc_en, sub_en, halt, clk_sw, err;
    int         n_chk = 0, n_bad = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .rst(rst), .stby_n_i(stby_n), .res_n_i(res_n), .sleep_i(sleep),
        .ssby_i(ctl[3]), .pss_i(ctl[2]), .dton_i(ctl[1]), .lson_i(ctl[0]),
        .ckdiv_i(ckdiv), .sts_i(sts), .subclk_tick_i(tick),
        .nmi_i(nmi), .irq_i(irq), .wdt0_i(wdt0), .wdt1_i(wdt1), .irq_ack_i(ack),
        .mode_o(mode), .main_osc_en_o(osc_en), .sub_en_o(sub_en),
        .cpu_halt_o(halt), .clk_sw_o(clk_sw), .sleep_err_o(err)
    );

    // R13 expectations per mode code
    function automatic logic [2:0] out_exp(input logic [3:0] m);
        logic o, s, h;
        o = (m == M_RST) || (m == M_HI) || (m == M_MD) || (m == M_SL);
        s = (m == M_WA) || (m == M_SA) || (m == M_SU);
        h = !((m == M_HI) || (m == M_MD) || (m == M_SA));
        return {o, s, h};
    endfunction

    task automatic check(input string rq, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        stby_n = 1'b1; res_n = 1'b1; sleep = 1'b0; ctl = '0;
        nmi = 1'b0; irq = '0; wdt0 = 1'b0; wdt1 = 1'b0; ack = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int n;
        int osc_bad;
        repeat (3) @(negedge clk);
        // reset state
        check("R2", mode, M_RST, "mode under rst");
        check("R12", err, 0, "error under rst");
        check("R6", clk_sw, 0, "switch pulse under rst");
        check("R13", {osc_en, sub_en, halt}, out_exp(M_RST), "enables under rst");
        rst = 1'b0;

        foreach (TBL[i]) begin
            stby_n = TBL[i].sn; res_n = TBL[i].rn; sleep = TBL[i].sl;
            ctl = TBL[i].ctl; ckdiv = TBL[i].div;
            nmi = TBL[i].wk[3]; irq = {2'b00, TBL[i].wk[2], 3'b000};
            wdt0 = TBL[i].wk[1]; wdt1 = TBL[i].wk[0]; ack = TBL[i].ack;
            @(negedge clk);
            check($sformatf("R%0d", TBL[i].rq), mode, TBL[i].em, $sformatf("row %0d mode", i));
            check($sformatf("R%0d", TBL[i].rq), err, TBL[i].ee, $sformatf("row %0d error flag", i));
            check($sformatf("R%0d", TBL[i].rq), clk_sw, TBL[i].esw, $sformatf("row %0d switch pulse", i));
            check("R13", {osc_en, sub_en, halt}, out_exp(TBL[i].em), $sformatf("row %0d enables", i));
        end

        // R10: subclock return with settling wait, two STS settings
        for (int s = 0; s < 2; s++) begin
            drive_idle();
            sleep = 1'b1; ctl = 4'b1111;
            @(negedge clk);
            drive_idle();
            @(negedge clk);
            check("R6", mode, M_SA, "entered sub-active");
            check("R13", {osc_en, sub_en, halt}, out_exp(M_SA), "sub-active enables");
            sleep = 1'b1; ctl = 4'b1110; sts = 3'(s);
            @(negedge clk);
            drive_idle();
            n = 0;
            osc_bad = 0;
            while (!clk_sw && n < 5000) begin
                if (mode != M_SA || !osc_en) osc_bad++;
                n++;
                @(negedge clk);
            end
            check("R10", n, 1 << (8 + s), $sformatf("settle cycles sts=%0d", s));
            check("R10", osc_bad, 0, "osc on in sub-active during wait");
            check("R10", mode, M_SA, "mode during switch pulse");
            @(negedge clk);
            check("R10", mode, M_HI, "high-speed after switch");
            check("R10", clk_sw, 0, "pulse is one cycle");
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule